// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers the interrupt sources of one peripheral and turns them into a single interrupt line. Each source has its own bit in a device status word. Most of those bits follow their source signal directly. Two bits are derived inside the block:

- **Bit 0** holds an internal error condition that stays set until software clears it.
- **Bit 2** summarises a second, finer-grained group of IP-specific events, each with its own enable.

Software enables sources one by one, and also controls a single global gate. The block presents three registers for polling and dispatch: the raw status, the enabled-and-set subset, and the number of the lowest pending source.

The register port is a plain 32-bit read/write interface addressed by byte offset. Reads are combinational. Writes take effect at the clock edge.

A keyed write to the reset register returns every register to its reset state. That event is also driven out as a one-cycle pulse, so attached logic can reset together with the block.

Top module: `irq_hub`

## Requirements
- R1: The byte offsets are: device status 0, device pending 4, device enable 8, source ID 24, global gate 28, IP status 32, IP enable 40, reset 64. Any other offset reads as zero, and writing to it changes no register.
- R2: Only bit 31 of the global gate register is stored; it reads back alone. `irq_out` can be 1 only while that bit is 1.
- R3: `irq_out` is 1 exactly when some device status bit and its device enable bit are both 1 and the global gate bit is 1.
- R4: Device status shows its sources whether or not they are enabled. Every bit other than 0 and 2 mirrors the same bit of `src_live` in the same cycle.
- R5: A write to device status leaves its live bits unchanged.
- R6: Status bit 0 is latched. A pulse on `err_evt` sets it. Each 1 written to bit 0 of the status offset inverts the stored bit, so the same write can either set or clear it.
- R7: The pending register reads as device status AND device enable.
- R8: The source ID register reads the index of the lowest set pending bit (LSB = 0). It reads 128 when no bit is pending.
- R9: Writing 0x0000000A to the reset offset drives `soft_rst_out` high for exactly one cycle, starting at the write edge. At the next edge every register returns to its reset value.
- R10: Writing any value other than 0x0000000A to the reset offset causes no pulse and changes no register.
- R11: IP status latches `ip_evt` pulses and uses the same invert-on-write-1 rule as R6. Device status bit 2 is the OR of (IP status AND IP enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (7) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_live | input | N_DEV (8) | Level interrupt sources; bits 0 and 2 are unused |
| err_evt | input | 1 | Internal error event pulse |
| ip_evt | input | N_IP (4) | IP-level event pulses |
| irq_out | output | 1 | Interrupt to the system |
| soft_rst_out | output | 1 | One-cycle reset pulse after a keyed reset write |

## Verification
The bench uses the default build of eight device sources and four IP-level events. With this build, a mix of live bits, the latched error bit and the folded IP bit can be set at the same time. The priority encoder therefore sees several competing candidates, including the case where the lowest pending index is 0.

Four IP events are enough to show that a toggle write clears one IP bit while another stays latched. That surviving bit keeps device bit 2 up.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int OFF_STAT   = 0;
    localparam int OFF_PEND   = 4;
    localparam int OFF_EN     = 8;
    localparam int OFF_ID     = 24;
    localparam int OFF_GATE   = 28;
    localparam int OFF_IPSTAT = 32;
    localparam int OFF_IPEN   = 40;
    localparam int OFF_RST    = 64;

    localparam logic [31:0] RST_KEY    = 32'h0000_000A;
    localparam logic [7:0]  NO_PEND_ID = 8'd128;
    localparam int          ERR_BIT    = 0;
    localparam int          IP_BIT     = 2;
    localparam int          GATE_BIT   = 31;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_STAT, SEL_PEND, SEL_EN, SEL_ID,
        SEL_GATE, SEL_IPSTAT, SEL_IPEN, SEL_RST
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [6:0] a);
        case (a)
            7'(OFF_STAT):   decode = SEL_STAT;
            7'(OFF_PEND):   decode = SEL_PEND;
            7'(OFF_EN):     decode = SEL_EN;
            7'(OFF_ID):     decode = SEL_ID;
            7'(OFF_GATE):   decode = SEL_GATE;
            7'(OFF_IPSTAT): decode = SEL_IPSTAT;
            7'(OFF_IPEN):   decode = SEL_IPEN;
            7'(OFF_RST):    decode = SEL_RST;
            default:        decode = SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irq_ip_level.sv
module irq_ip_level #(
    parameter int N_IP = 4
) (
    input  logic            clk,
    input  logic            rst_any,
    input  logic [N_IP-1:0] ip_evt,
    input  logic            wr_stat,
    input  logic            wr_en,
    input  logic [N_IP-1:0] wdata,
    output logic [N_IP-1:0] ip_stat,
    output logic [N_IP-1:0] ip_en,
    output logic            ip_irq
);
    always_ff @(posedge clk) begin
        if (rst_any) begin
            ip_stat <= '0;
            ip_en   <= '0;
        end else begin
            ip_stat <= (ip_stat ^ (wr_stat ? wdata : '0)) | ip_evt;
            if (wr_en) ip_en <= wdata;
        end
    end

    assign ip_irq = |(ip_stat & ip_en);

    assert_ip_toggle_R11: assert property (@(posedge clk) disable iff (rst_any)
        (wr_stat && ip_evt == '0) |=> ip_stat == ($past(ip_stat) ^ $past(wdata)));
    assert_ip_event_R11: assert property (@(posedge clk) disable iff (rst_any)
        (!wr_stat && ip_evt != '0) |=> ((ip_stat & $past(ip_evt)) == $past(ip_evt)));
endmodule

// File: rtl/irq_dev_status.sv
module irq_dev_status
    import irq_pkg::*;
#(
    parameter int N_DEV = 8
) (
    input  logic             clk,
    input  logic             rst_any,
    input  logic [N_DEV-1:0] src_live,
    input  logic             err_evt,
    input  logic             ip_irq,
    input  logic             wr_stat,
    input  logic             wbit_err,
    output logic [N_DEV-1:0] status
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst_any) err_q <= 1'b0;
        else         err_q <= (err_q ^ (wr_stat & wbit_err)) | err_evt;
    end

    for (genvar i = 0; i < N_DEV; i++) begin : g_bit
        if (i == ERR_BIT) begin : g_err
            assign status[i] = err_q;
        end else if (i == IP_BIT) begin : g_ip
            assign status[i] = ip_irq;
        end else begin : g_live
            assign status[i] = src_live[i];
        end
    end

    assert_err_toggle_R6: assert property (@(posedge clk) disable iff (rst_any)
        (wr_stat && !err_evt) |=> err_q == ($past(err_q) ^ $past(wbit_err)));
    assert_err_event_R6: assert property (@(posedge clk) disable iff (rst_any)
        err_evt |=> err_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] pend,
    output logic [7:0]   id
);
    always_comb begin
        id = NO_PEND_ID;
        for (int i = N - 1; i >= 0; i--)
            if (pend[i]) id = 8'(i);
    end

    always_comb begin
        if (id != NO_PEND_ID)
            assert_id_valid_R8: assert (pend[id[6:0]] && (pend & ((N'(1) << id[6:0]) - N'(1))) == '0);
        else
            assert_id_empty_R8: assert (pend == '0);
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_pkg::*;
#(
    parameter int N_DEV  = 8,
    parameter int N_IP   = 4,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_DEV-1:0]  src_live,
    input  logic              err_evt,
    input  logic [N_IP-1:0]   ip_evt,
    output logic              irq_out,
    output logic              soft_rst_out
);
    reg_sel_e         sel;
    logic             rst_any;
    logic             soft_rst_q;
    logic [N_DEV-1:0] dev_en;
    logic             gate_q;
    logic [N_DEV-1:0] status;
    logic [N_DEV-1:0] pend;
    logic [N_IP-1:0]  ip_stat, ip_en;
    logic             ip_irq;
    logic [7:0]       id;

    assign sel     = decode(7'(reg_addr));
    assign rst_any = rst | soft_rst_q;

    always_ff @(posedge clk) begin
        if (rst) soft_rst_q <= 1'b0;
        else     soft_rst_q <= reg_wr && sel == SEL_RST && reg_wdata == RST_KEY;
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            dev_en <= '0;
            gate_q <= 1'b0;
        end else if (reg_wr) begin
            if (sel == SEL_EN)   dev_en <= reg_wdata[N_DEV-1:0];
            if (sel == SEL_GATE) gate_q <= reg_wdata[GATE_BIT];
        end
    end

    irq_ip_level #(.N_IP(N_IP)) u_ip (
        .clk(clk), .rst_any(rst_any), .ip_evt(ip_evt),
        .wr_stat(reg_wr && sel == SEL_IPSTAT), .wr_en(reg_wr && sel == SEL_IPEN),
        .wdata(reg_wdata[N_IP-1:0]), .ip_stat(ip_stat), .ip_en(ip_en), .ip_irq(ip_irq)
    );

    irq_dev_status #(.N_DEV(N_DEV)) u_stat (
        .clk(clk), .rst_any(rst_any), .src_live(src_live), .err_evt(err_evt),
        .ip_irq(ip_irq), .wr_stat(reg_wr && sel == SEL_STAT),
        .wbit_err(reg_wdata[ERR_BIT]), .status(status)
    );

    assign pend = status & dev_en;

    irq_prio_enc #(.N(N_DEV)) u_enc (.pend(pend), .id(id));

    assign irq_out      = gate_q & (|pend);
    assign soft_rst_out = soft_rst_q;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STAT:   reg_rdata[N_DEV-1:0] = status;
            SEL_PEND:   reg_rdata[N_DEV-1:0] = pend;
            SEL_EN:     reg_rdata[N_DEV-1:0] = dev_en;
            SEL_ID:     reg_rdata[7:0]       = id;
            SEL_GATE:   reg_rdata[GATE_BIT]  = gate_q;
            SEL_IPSTAT: reg_rdata[N_IP-1:0]  = ip_stat;
            SEL_IPEN:   reg_rdata[N_IP-1:0]  = ip_en;
            default:    reg_rdata = '0;
        endcase
    end

    assert_irq_gated_R2: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> gate_q);
    assert_irq_has_id_R3: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> id != NO_PEND_ID);
    assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        soft_rst_q |=> (!soft_rst_q && dev_en == '0 && !gate_q));
    assert_bad_key_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel == SEL_RST && reg_wdata != RST_KEY) |=> !soft_rst_out);
endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  src_live = '0;
    logic        err_evt = 0;
    logic [3:0]  ip_evt = '0;
    logic        irq_out, soft_rst_out;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    irq_hub u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_live(src_live),
        .err_evt(err_evt), .ip_evt(ip_evt), .irq_out(irq_out),
        .soft_rst_out(soft_rst_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 7'(a); reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 7'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(24, v); chk("R8 reset id", v, 32'd128);
        rd(0, v);  chk("R4 reset status", v, 0);
        chk("R3 reset irq", {31'b0, irq_out}, 0);
        chk("R9 reset pulse idle", {31'b0, soft_rst_out}, 0);
    endtask

    task automatic t_live();
        logic [31:0] v;
        src_live = 8'hAD;
        rd(0, v); chk("R4 live mirror", v, 32'hA8);
        wr(0, 32'hFE);
        rd(0, v); chk("R5 live write ignored", v, 32'hA8);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(8, 32'h28);
        rd(8, v);  chk("R1 enable readback", v, 32'h28);
        rd(4, v);  chk("R7 pending", v, 32'h28);
        rd(24, v); chk("R8 lowest id", v, 3);
        chk("R2 no irq without gate", {31'b0, irq_out}, 0);
        wr(28, 32'hFFFF_FFFF);
        rd(28, v); chk("R2 gate bit only", v, 32'h8000_0000);
        chk("R3 irq asserted", {31'b0, irq_out}, 1);
        src_live = 8'h00;
        rd(4, v);  chk("R7 pending empty", v, 0);
        rd(24, v); chk("R8 none pending", v, 32'd128);
        chk("R3 irq drops", {31'b0, irq_out}, 0);
    endtask

    task automatic t_err();
        logic [31:0] v;
        wr(8, 32'h01);
        wr(0, 32'h01);
        rd(0, v);  chk("R6 write sets latched bit", v, 1);
        rd(24, v); chk("R8 id zero", v, 0);
        chk("R3 irq from error", {31'b0, irq_out}, 1);
        wr(0, 32'h01);
        rd(0, v);  chk("R6 write clears latched bit", v, 0);
        @(negedge clk); err_evt = 1;
        @(negedge clk); err_evt = 0;
        rd(0, v);  chk("R6 event sets bit", v, 1);
    endtask

    task automatic t_ip();
        logic [31:0] v;
        @(negedge clk); ip_evt = 4'b0101;
        @(negedge clk); ip_evt = 4'b0000;
        rd(32, v); chk("R11 ip latch", v, 5);
        rd(0, v);  chk("R11 ip masked", v & 32'h4, 0);
        wr(40, 32'h4);
        rd(0, v);  chk("R11 ip folds into bit2", v & 32'h4, 4);
        wr(32, 32'h1);
        rd(32, v); chk("R11 ip toggle clears one", v, 4);
        rd(0, v);  chk("R11 bit2 held", v & 32'h4, 4);
        wr(32, 32'h4);
        rd(0, v);  chk("R11 bit2 drops", v & 32'h4, 0);
    endtask

    task automatic t_hole();
        logic [31:0] v;
        wr(12, 32'hFF);
        rd(12, v); chk("R1 hole reads zero", v, 0);
        rd(8, v);  chk("R1 hole write harmless", v, 32'h01);
    endtask

    task automatic t_soft_rst();
        logic [31:0] v;
        wr(28, 32'h8000_0000);
        wr(64, 32'h5);
        chk("R10 bad key no pulse", {31'b0, soft_rst_out}, 0);
        rd(8, v);  chk("R10 enable kept", v, 1);
        rd(28, v); chk("R10 gate kept", v, 32'h8000_0000);
        wr(64, 32'hA);
        chk("R9 pulse high", {31'b0, soft_rst_out}, 1);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'b0, soft_rst_out}, 0);
        rd(8, v);  chk("R9 enable cleared", v, 0);
        rd(28, v); chk("R9 gate cleared", v, 0);
        rd(0, v);  chk("R9 status cleared", v, 0);
        rd(24, v); chk("R9 id idle", v, 32'd128);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_live();
        t_gate();
        t_err();
        t_ip();
        t_hole();
        t_soft_rst();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule